// File: doc/BRIEF.md
# UART Hardware Handshake Unit

This block holds the request-to-send / clear-to-send handshake for a single UART channel. On the transmit side it reads the active-low clear-to-send pin and tells the transmitter whether it may begin the next character. A change on the pin is acted on only when the transmitter reports that it is at a character boundary. A character that is already being shifted out is therefore always finished.

On the receive side it drives the active-low request-to-send pin. Two sources meet in a NAND-style combination at that pin:
- **Software output bit.** Software sets and clears it with commands.
- **Automatic request.** The receiver withdraws it when a valid start bit arrives while its FIFO is already full. It returns as soon as a FIFO slot frees up.

The pin goes low only while the output bit is in its asserting state and the automatic request is not withdrawn.

Top module: `uart_hs_flow`

## Requirements
- R1: After reset the output bit is cleared (pin `rts_n_pin` high), automatic RTS is not withdrawn, and with `cts_gate_en` low `tx_allow` is 1.
- R2: While `cts_gate_en` is 0, `tx_allow` is 1 whatever `cts_n_pin` does.
- R3: While `cts_gate_en` is 1, `cts_n_pin` passes through a two-flop synchronizer. At every clock edge where `tx_at_boundary` is 1, the permission register takes the inverse of the synchronized value. A pin change before edge k is therefore seen at `tx_allow` after edge k+2 if `tx_at_boundary` is held high.
- R4: While `tx_at_boundary` is 0 and `cts_gate_en` is 1, `tx_allow` holds its value, so a character in progress is never cut off.
- R5: A one-cycle `opbit_set` puts the output bit in its asserting state and `opbit_clr` removes it; when both are high in one cycle, clear wins. With automatic RTS off, `rts_n_pin` is the inverse of the output bit.
- R6: With `auto_rts_en` 1, a `rx_start_valid` pulse while `rx_fifo_full` is 1 and `rx_fifo_read` is 0 withdraws the automatic request, so `rts_n_pin` is high after the next edge.
- R7: A `rx_start_valid` pulse while `rx_fifo_full` is 0 does not withdraw the request.
- R8: A withdrawn request is restored at the edge where `rx_fifo_read` is 1 or `rx_fifo_full` is 0, unless a new withdrawal occurs in that same cycle.
- R9: With the output bit cleared, `rts_n_pin` is high regardless of the automatic request.
- R10: Setting or clearing `auto_rts_en` never changes the output bit. Clearing it discards any withdrawal at once, so the pin again follows the output bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| cts_gate_en | input | 1 | Mode bit: clear-to-send gates the transmitter |
| auto_rts_en | input | 1 | Mode bit: receiver controls request-to-send |
| opbit_set | input | 1 | Command pulse: put output bit in asserting state |
| opbit_clr | input | 1 | Command pulse: put output bit in non-asserting state |
| rx_fifo_full | input | 1 | Receiver FIFO full flag |
| rx_start_valid | input | 1 | Pulse: receiver detected a valid start bit |
| rx_fifo_read | input | 1 | Pulse: one FIFO entry read |
| tx_at_boundary | input | 1 | Transmitter is idle or finishing a character |
| tx_allow | output | 1 | Transmitter may start a character |
| rts_n_pin | output | 1 | Request-to-send pin, active low |

## Verification
The hardest state to reach from the ports is a clear-to-send change that lands while the transmitter is mid-character. The synchronized value has to be pending, and has to stay unused for several cycles until the boundary returns. The stimulus holds `tx_at_boundary` low, moves the pin, waits well past the synchronizer latency, and only then raises the boundary.

A second hard case is a withdrawal that coincides with a FIFO read or a mode change. Here directed cycles place the start pulse, the read pulse and the enable drop in the same clock. Random runs then mix these events under a bench-side cycle model.

// File: rtl/uart_hs_flow.sv
module uart_hs_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_pin,
  input  logic cts_gate_en,
  input  logic auto_rts_en,
  input  logic opbit_set,
  input  logic opbit_clr,
  input  logic rx_fifo_full,
  input  logic rx_start_valid,
  input  logic rx_fifo_read,
  input  logic tx_at_boundary,
  output logic tx_allow,
  output logic rts_n_pin
);

  logic cts_m, cts_s, allow_q, obit, drop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_m <= 1'b1;
      cts_s <= 1'b1;
    end else begin
      cts_m <= cts_n_pin;
      cts_s <= cts_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              allow_q <= 1'b1;
    else if (tx_at_boundary) allow_q <= ~cts_s;

  assign tx_allow = ~cts_gate_en | allow_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         obit <= 1'b0;
    else if (opbit_clr) obit <= 1'b0;
    else if (opbit_set) obit <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                             drop <= 1'b0;
    else if (!auto_rts_en)                                  drop <= 1'b0;
    else if (rx_start_valid && rx_fifo_full && !rx_fifo_read) drop <= 1'b1;
    else if (rx_fifo_read || !rx_fifo_full)                 drop <= 1'b0;

  assign rts_n_pin = ~(obit & ~(auto_rts_en & drop));

  assert_hold_midchar_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate_en && $past(cts_gate_en) && !$past(tx_at_boundary)) |-> tx_allow == $past(tx_allow));

  assert_block_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_gate_en && tx_at_boundary && cts_s) |=> (!tx_allow || !cts_gate_en));

  assert_clear_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    opbit_clr |=> rts_n_pin);

  assert_set_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opbit_set && !opbit_clr && !auto_rts_en) |=> !rts_n_pin);

  assert_withdraw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_start_valid && rx_fifo_full && !rx_fifo_read) |=> (rts_n_pin || !auto_rts_en));

  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_read && !rx_start_valid) |=> (rts_n_pin == ~obit));

endmodule

// File: tb/uart_hs_flow_test.sv
module uart_hs_flow_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n_pin = 1'b1, cts_gate_en = 1'b0, auto_rts_en = 1'b0;
  logic opbit_set = 1'b0, opbit_clr = 1'b0, rx_fifo_full = 1'b0;
  logic rx_start_valid = 1'b0, rx_fifo_read = 1'b0, tx_at_boundary = 1'b1;
  logic tx_allow, rts_n_pin;
  int checks = 0, failures = 0;
  bit m_s1 = 1, m_s2 = 1, m_allow = 1, m_obit = 0, m_drop = 0;

  always #2.5 clk = ~clk;

  uart_hs_flow uut (.*);

  function automatic bit exp_allow();
    return !cts_gate_en || m_allow;
  endfunction

  function automatic bit exp_rts();
    return !(m_obit && !(auto_rts_en && m_drop));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    m_allow = tx_at_boundary ? !m_s2 : m_allow;
    m_s2 = m_s1;
    m_s1 = cts_n_pin;
    if (opbit_clr) m_obit = 0; else if (opbit_set) m_obit = 1;
    if (!auto_rts_en) m_drop = 0;
    else if (rx_start_valid && rx_fifo_full && !rx_fifo_read) m_drop = 1;
    else if (rx_fifo_read || !rx_fifo_full) m_drop = 0;
    @(negedge clk);
    check({tag, " tx_allow"}, tx_allow, exp_allow());
    check({tag, " rts_n"}, rts_n_pin, exp_rts());
  endtask

  task automatic pulse_clear();
    opbit_set = 0; opbit_clr = 0; rx_start_valid = 0; rx_fifo_read = 0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    check("R1 reset tx_allow", tx_allow, 1'b1);
    check("R1 reset rts_n", rts_n_pin, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cyc("R1");
    check("R1 idle rts_n", rts_n_pin, 1'b1);

    opbit_set = 1; cyc("R5"); pulse_clear();
    check("R5 set", rts_n_pin, 1'b0);
    opbit_set = 1; opbit_clr = 1; cyc("R5"); pulse_clear();
    check("R5 clear wins", rts_n_pin, 1'b1);
    opbit_set = 1; cyc("R5"); pulse_clear();

    auto_rts_en = 1; cyc("R10");
    check("R10 enable keeps bit", rts_n_pin, 1'b0);
    rx_start_valid = 1; cyc("R7"); pulse_clear();
    check("R7 start no full", rts_n_pin, 1'b0);
    rx_fifo_full = 1; cyc("R7");
    rx_start_valid = 1; cyc("R6"); pulse_clear();
    check("R6 withdraw", rts_n_pin, 1'b1);
    cyc("R6");
    check("R6 stays withdrawn", rts_n_pin, 1'b1);
    rx_fifo_read = 1; cyc("R8"); pulse_clear();
    check("R8 read restores", rts_n_pin, 1'b0);
    rx_start_valid = 1; rx_fifo_read = 1; cyc("R8"); pulse_clear();
    check("R8 start with read", rts_n_pin, 1'b0);
    rx_start_valid = 1; cyc("R6"); pulse_clear();
    rx_fifo_full = 0; cyc("R8");
    check("R8 full drop restores", rts_n_pin, 1'b0);
    rx_fifo_full = 1; rx_start_valid = 1; cyc("R6"); pulse_clear();
    opbit_clr = 1; cyc("R9"); pulse_clear();
    check("R9 bit clear", rts_n_pin, 1'b1);
    rx_fifo_read = 1; cyc("R9"); pulse_clear();
    check("R9 restored but bit clear", rts_n_pin, 1'b1);
    opbit_set = 1; rx_start_valid = 1; cyc("R6"); pulse_clear();
    check("R6 set with withdraw", rts_n_pin, 1'b1);
    auto_rts_en = 0; #0;
    check("R10 disable returns to bit", rts_n_pin, 1'b0);
    cyc("R10");
    auto_rts_en = 1; #0;
    check("R10 re-enable no stale drop", rts_n_pin, 1'b0);
    rx_fifo_full = 0; auto_rts_en = 0;

    cts_gate_en = 1; tx_at_boundary = 1; cts_n_pin = 1;
    cyc("R3"); cyc("R3"); cyc("R3");
    check("R3 blocked at boundary", tx_allow, 1'b0);
    cts_n_pin = 0; cyc("R3"); cyc("R3");
    check("R3 sync latency", tx_allow, 1'b0);
    cyc("R3");
    check("R3 released", tx_allow, 1'b1);
    tx_at_boundary = 0; cts_n_pin = 1;
    for (int i = 0; i < 6; i++) cyc("R4");
    check("R4 mid-char hold", tx_allow, 1'b1);
    tx_at_boundary = 1; cyc("R4");
    check("R4 boundary blocks", tx_allow, 1'b0);
    cts_gate_en = 0; #0;
    check("R2 gate off", tx_allow, 1'b1);
    for (int i = 0; i < 4; i++) cyc("R2");
    check("R2 pin ignored", tx_allow, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      cts_n_pin      = ($urandom % 4) == 0 ? ~cts_n_pin : cts_n_pin;
      cts_gate_en    = ($urandom % 16) != 0;
      auto_rts_en    = ($urandom % 12) != 0;
      opbit_set      = ($urandom % 10) == 0;
      opbit_clr      = ($urandom % 25) == 0;
      rx_fifo_full   = ($urandom % 3) != 0;
      rx_start_valid = ($urandom % 4) == 0;
      rx_fifo_read   = ($urandom % 6) == 0;
      tx_at_boundary = ($urandom % 8) == 0;
      cyc("RND R3 R4 R6 R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule